// File: doc/BRIEF.md
# Two-Way Read Cache with Per-Unit Valid Bits

This block sits between a processor fetch port and a slower word-wide backing memory and serves reads only. Storage is organised in sets of two ways. Each way holds one tag, a line-valid flag and a line of four data units, and every data unit carries its own valid flag. A lookup hits only when the tag matches a valid line and the addressed unit is valid. On a miss only the needed unit is read from memory, one word per memory beat. The replacement choice within a set uses a most-recently-used flag kept for each set.

A control port enables the cache, sets an update lock and sets a one-way read lock. With the cache disabled, fetches go straight to memory. With the update lock set, lookups and hits continue, but misses are served without changing the cache. With the read lock set, the debug read port stops showing tags and data. The block accepts one fetch at a time. The debug port reads back tag, line and unit flags, one data word and the most-recently-used flag for a chosen set and way.

Top module: `rc_cache`

## Requirements
- R1: With default parameters a 16-bit word address splits as follows: bit 0 is the word within a unit, bits 2:1 are the unit, bits 5:3 are the set and bits 15:6 are the tag. The line word index is bits 2:0, and the unit is that index divided by the words per unit.
- R2: A hit needs a tag match on a valid line whose addressed unit is valid. Its response (resp_hit=1, the stored word) appears in the second cycle after the accepting edge.
- R3: A miss reads only the words of the needed unit, from the unit base upward. mem_req stays high with a stable mem_addr until mem_rvalid. The response carries the requested word with resp_hit=0.
- R4: A miss on a valid line with a matching tag refills only that unit and keeps the other unit flags. A fill with a new tag leaves only the filled unit marked valid. In dbg_unit_valid, bit u stands for unit u.
- R5: The fill way is chosen in this order: a matching-tag way; then an invalid way, way 0 before way 1; then the way that is not most recently used. Every hit and every fill sets the set's most-recently-used flag to that way.
- R6: While cfg_enable is low, a fetch makes one memory read of its own address and answers with resp_hit=0. Tags, flags and data stay unchanged.
- R7: While cfg_update_lock is high at lookup time, a miss is served from memory but writes nothing and leaves the most-recently-used flag unchanged. Hits are still served.
- R8: Once cfg_read_lock has been high for a cycle, every debug read returns dbg_denied=1 with all fields zero. Only rst_n clears this state.
- R9: A debug request gives dbg_rvalid one cycle later. The fields show the state before that edge: tag, line flag, unit flags, the chosen word of the line and the set's most-recently-used flag.
- R10: fetch_ready is high only while no fetch is in progress. After reset, fetch_ready=1, resp_valid=0, mem_req=0 and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also clears the read lock |
| cfg_enable | input | 1 | Cache enable; low means bypass |
| cfg_update_lock | input | 1 | Blocks fills while lookups continue |
| cfg_read_lock | input | 1 | Sets the sticky debug read lock |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Fetch word address |
| fetch_ready | output | 1 | Idle, request may be taken |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DATA_W | Fetched word |
| resp_hit | output | 1 | 1 = served from the cache |
| mem_req | output | 1 | Backing memory read request |
| mem_addr | output | ADDR_W | Backing memory word address |
| mem_rvalid | input | 1 | Memory word returned |
| mem_rdata | input | DATA_W | Memory word |
| dbg_req | input | 1 | Debug read request |
| dbg_set | input | log2(SETS) | Debug set |
| dbg_way | input | 1 | Debug way |
| dbg_word | input | log2(WPU*UNITS) | Debug word within line |
| dbg_rvalid | output | 1 | Debug result valid |
| dbg_denied | output | 1 | Debug read blocked by the read lock |
| dbg_tag | output | TAG_W | Stored tag |
| dbg_line_valid | output | 1 | Line valid flag |
| dbg_unit_valid | output | UNITS | Unit valid flags |
| dbg_data | output | DATA_W | Stored word |
| dbg_mru | output | 1 | Most recently used way of the set |

## Verification
A debug read can be captured at the same edge at which a fill writes the tag and flags of the line being read. The bench holds dbg_req high on set 3, way 0 while a miss fills that line. In the cycle where the fetch response appears, the debug result must still show the line as invalid, because it was sampled before the write. One cycle later it must show the line valid, the single unit flag and the fetched word. The fetch response itself must be unaffected by the debug traffic.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2,
    ST_BYP  = 2'd3
  } rc_state_e;
endpackage

// File: rtl/rc_tag_store.sv
module rc_tag_store #(
  parameter int SETS  = 8,
  parameter int UNITS = 4,
  parameter int TAG_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  lk_set,
  input  logic [TAG_W-1:0]         lk_tag,
  input  logic [$clog2(UNITS)-1:0] lk_unit,
  output logic                     lk_hit,
  output logic                     lk_hit_way,
  output logic                     lk_fill_way,
  output logic                     lk_fill_new,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  wr_set,
  input  logic                     wr_way,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [$clog2(UNITS)-1:0] wr_unit,
  input  logic                     wr_new,
  input  logic                     mru_we,
  input  logic [$clog2(SETS)-1:0]  mru_set,
  input  logic                     mru_way,
  input  logic [$clog2(SETS)-1:0]  dq_set,
  input  logic                     dq_way,
  output logic [TAG_W-1:0]         dq_tag,
  output logic                     dq_lv,
  output logic [UNITS-1:0]         dq_uv,
  output logic                     dq_mru
);
  localparam int WAYS = 2;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic             lv_q  [SETS][WAYS];
  logic [UNITS-1:0] uv_q  [SETS][WAYS];
  logic             mru_q [SETS];

  logic [WAYS-1:0] match;
  logic [WAYS-1:0] uhit;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match[w] = lv_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      assign uhit[w]  = match[w] && uv_q[lk_set][w][lk_unit];
    end
  endgenerate

  assign lk_hit     = |uhit;
  assign lk_hit_way = uhit[1];

  // fill way: matching line, then free way (way 0 first), then non-MRU
  always_comb begin
    lk_fill_new = 1'b1;
    if (|match) begin
      lk_fill_way = match[1];
      lk_fill_new = 1'b0;
    end else if (!lv_q[lk_set][0]) begin
      lk_fill_way = 1'b0;
    end else if (!lv_q[lk_set][1]) begin
      lk_fill_way = 1'b1;
    end else begin
      lk_fill_way = !mru_q[lk_set];
    end
  end

  logic [UNITS-1:0] unit_bit;
  assign unit_bit = UNITS'(1) << wr_unit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        mru_q[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          lv_q[s][w]  <= 1'b0;
          uv_q[s][w]  <= '0;
        end
      end
    end else begin
      if (wr_en) begin
        tag_q[wr_set][wr_way] <= wr_tag;
        lv_q[wr_set][wr_way]  <= 1'b1;
        uv_q[wr_set][wr_way]  <= wr_new ? unit_bit : (uv_q[wr_set][wr_way] | unit_bit);
      end
      if (mru_we) mru_q[mru_set] <= mru_way;
    end
  end

  assign dq_tag = tag_q[dq_set][dq_way];
  assign dq_lv  = lv_q[dq_set][dq_way];
  assign dq_uv  = uv_q[dq_set][dq_way];
  assign dq_mru = mru_q[dq_set];

  a_r5_mru_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    mru_we |=> (mru_q[$past(mru_set)] == $past(mru_way)));
  a_r4_unit_marked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (uv_q[$past(wr_set)][$past(wr_way)][$past(wr_unit)] && lv_q[$past(wr_set)][$past(wr_way)]));
  a_r4_new_line_single: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_new) |=> ($countones(uv_q[$past(wr_set)][$past(wr_way)]) == 1));
endmodule

// File: rtl/rc_data_store.sv
module rc_data_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wa,
  input  logic [DATA_W-1:0]        wd,
  input  logic [$clog2(DEPTH)-1:0] ra,
  output logic [DATA_W-1:0]        rd_a,
  input  logic [$clog2(DEPTH)-1:0] rb,
  output logic [DATA_W-1:0]        rd_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd_a = mem[ra];
  assign rd_b = mem[rb];
endmodule

// File: rtl/rc_dbg_read.sv
module rc_dbg_read #(
  parameter int TAG_W  = 10,
  parameter int UNITS  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_req,
  input  logic              rd_req,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_lv,
  input  logic [UNITS-1:0]  in_uv,
  input  logic              in_mru,
  input  logic [DATA_W-1:0] in_data,
  output logic              rvalid,
  output logic              denied,
  output logic [TAG_W-1:0]  o_tag,
  output logic              o_lv,
  output logic [UNITS-1:0]  o_uv,
  output logic              o_mru,
  output logic [DATA_W-1:0] o_data
);
  logic lock_q;
  logic blocked;
  assign blocked = lock_q || lock_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      rvalid <= 1'b0;
      denied <= 1'b0;
      o_tag  <= '0;
      o_lv   <= 1'b0;
      o_uv   <= '0;
      o_mru  <= 1'b0;
      o_data <= '0;
    end else begin
      if (lock_req) lock_q <= 1'b1;
      rvalid <= rd_req;
      if (rd_req) begin
        denied <= blocked;
        o_tag  <= blocked ? '0 : in_tag;
        o_lv   <= blocked ? 1'b0 : in_lv;
        o_uv   <= blocked ? '0 : in_uv;
        o_mru  <= blocked ? 1'b0 : in_mru;
        o_data <= blocked ? '0 : in_data;
      end
    end
  end

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r8_denied_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && lock_q) |=> (rvalid && denied));
  a_r9_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid);
endmodule

// File: rtl/rc_cache.sv
module rc_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WPU    = 2,
  parameter int UNITS  = 4
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           cfg_enable,
  input  logic                                           cfg_update_lock,
  input  logic                                           cfg_read_lock,
  input  logic                                           fetch_valid,
  input  logic [ADDR_W-1:0]                              fetch_addr,
  output logic                                           fetch_ready,
  output logic                                           resp_valid,
  output logic [DATA_W-1:0]                              resp_data,
  output logic                                           resp_hit,
  output logic                                           mem_req,
  output logic [ADDR_W-1:0]                              mem_addr,
  input  logic                                           mem_rvalid,
  input  logic [DATA_W-1:0]                              mem_rdata,
  input  logic                                           dbg_req,
  input  logic [$clog2(SETS)-1:0]                        dbg_set,
  input  logic                                           dbg_way,
  input  logic [$clog2(WPU*UNITS)-1:0]                   dbg_word,
  output logic                                           dbg_rvalid,
  output logic                                           dbg_denied,
  output logic [ADDR_W-$clog2(WPU*UNITS)-$clog2(SETS)-1:0] dbg_tag,
  output logic                                           dbg_line_valid,
  output logic [UNITS-1:0]                               dbg_unit_valid,
  output logic [DATA_W-1:0]                              dbg_data,
  output logic                                           dbg_mru
);
  import rc_pkg::*;

  localparam int WOFF_W = $clog2(WPU);
  localparam int UNIT_W = $clog2(UNITS);
  localparam int LW     = WPU * UNITS;
  localparam int LWI_W  = $clog2(LW);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - LWI_W - SET_W;
  localparam int DEPTH  = SETS * 2 * LW;
  localparam int DIDX_W = $clog2(DEPTH);
  localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(WPU - 1);

  // address field helpers
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[LWI_W +: SET_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [UNIT_W-1:0] f_unit(input logic [ADDR_W-1:0] a);
    return a[WOFF_W +: UNIT_W];
  endfunction
  function automatic logic [WOFF_W-1:0] f_woff(input logic [ADDR_W-1:0] a);
    return a[WOFF_W-1:0];
  endfunction

  rc_state_e         st_q;
  logic [ADDR_W-1:0] a_q;
  logic [WOFF_W-1:0] beat_q;
  logic [DATA_W-1:0] cap_q;
  logic              fway_q, fnew_q, flk_q;
  logic              resp_valid_q, resp_hit_q;
  logic [DATA_W-1:0] resp_data_q;

  logic              lk_hit, lk_hit_way, lk_fill_way, lk_fill_new;
  logic [TAG_W-1:0]  dq_tag;
  logic              dq_lv, dq_mru;
  logic [UNITS-1:0]  dq_uv;
  logic [DATA_W-1:0] hit_word, dbg_word_data;

  // named internal events
  logic ev_accept, ev_look, ev_hit, ev_miss, ev_byp, ev_beat, ev_last, ev_byp_done;
  logic beat_is_req, dat_we, tag_we, mru_we, mru_way;

  assign ev_accept   = fetch_valid && (st_q == ST_IDLE);
  assign ev_look     = (st_q == ST_LOOK);
  assign ev_hit      = ev_look && cfg_enable && lk_hit;
  assign ev_miss     = ev_look && cfg_enable && !lk_hit;
  assign ev_byp      = ev_look && !cfg_enable;
  assign ev_beat     = (st_q == ST_FILL) && mem_rvalid;
  assign ev_last     = ev_beat && (beat_q == LAST_BEAT);
  assign ev_byp_done = (st_q == ST_BYP) && mem_rvalid;
  assign beat_is_req = (beat_q == f_woff(a_q));
  assign dat_we      = ev_beat && !flk_q;
  assign tag_we      = ev_last && !flk_q;
  assign mru_we      = ev_hit || tag_we;
  assign mru_way     = ev_hit ? lk_hit_way : fway_q;

  rc_tag_store #(.SETS(SETS), .UNITS(UNITS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_set(f_set(a_q)), .lk_tag(f_tag(a_q)), .lk_unit(f_unit(a_q)),
    .lk_hit(lk_hit), .lk_hit_way(lk_hit_way),
    .lk_fill_way(lk_fill_way), .lk_fill_new(lk_fill_new),
    .wr_en(tag_we), .wr_set(f_set(a_q)), .wr_way(fway_q), .wr_tag(f_tag(a_q)),
    .wr_unit(f_unit(a_q)), .wr_new(fnew_q),
    .mru_we(mru_we), .mru_set(f_set(a_q)), .mru_way(mru_way),
    .dq_set(dbg_set), .dq_way(dbg_way),
    .dq_tag(dq_tag), .dq_lv(dq_lv), .dq_uv(dq_uv), .dq_mru(dq_mru)
  );

  rc_data_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk),
    .we(dat_we),
    .wa(DIDX_W'({f_set(a_q), fway_q, f_unit(a_q), beat_q})),
    .wd(mem_rdata),
    .ra(DIDX_W'({f_set(a_q), lk_hit_way, a_q[LWI_W-1:0]})),
    .rd_a(hit_word),
    .rb(DIDX_W'({dbg_set, dbg_way, dbg_word})),
    .rd_b(dbg_word_data)
  );

  rc_dbg_read #(.TAG_W(TAG_W), .UNITS(UNITS), .DATA_W(DATA_W)) u_dbg (
    .clk(clk), .rst_n(rst_n),
    .lock_req(cfg_read_lock), .rd_req(dbg_req),
    .in_tag(dq_tag), .in_lv(dq_lv), .in_uv(dq_uv), .in_mru(dq_mru), .in_data(dbg_word_data),
    .rvalid(dbg_rvalid), .denied(dbg_denied),
    .o_tag(dbg_tag), .o_lv(dbg_line_valid), .o_uv(dbg_unit_valid),
    .o_mru(dbg_mru), .o_data(dbg_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      a_q          <= '0;
      beat_q       <= '0;
      cap_q        <= '0;
      fway_q       <= 1'b0;
      fnew_q       <= 1'b0;
      flk_q        <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (ev_accept) begin
          a_q  <= fetch_addr;
          st_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (ev_byp) begin
            st_q <= ST_BYP;
          end else if (ev_hit) begin
            resp_valid_q <= 1'b1;
            resp_hit_q   <= 1'b1;
            resp_data_q  <= hit_word;
            st_q         <= ST_IDLE;
          end else if (ev_miss) begin
            beat_q <= '0;
            fway_q <= lk_fill_way;
            fnew_q <= lk_fill_new;
            flk_q  <= cfg_update_lock;
            st_q   <= ST_FILL;
          end
        end
        ST_FILL: if (ev_beat) begin
          if (beat_is_req) cap_q <= mem_rdata;
          if (ev_last) begin
            resp_valid_q <= 1'b1;
            resp_hit_q   <= 1'b0;
            resp_data_q  <= beat_is_req ? mem_rdata : cap_q;
            st_q         <= ST_IDLE;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_BYP: if (ev_byp_done) begin
          resp_valid_q <= 1'b1;
          resp_hit_q   <= 1'b0;
          resp_data_q  <= mem_rdata;
          st_q         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready = (st_q == ST_IDLE);
  assign resp_valid  = resp_valid_q;
  assign resp_hit    = resp_hit_q;
  assign resp_data   = resp_data_q;
  assign mem_req     = (st_q == ST_FILL) || (st_q == ST_BYP);
  assign mem_addr    = (st_q == ST_FILL) ? {a_q[ADDR_W-1:WOFF_W], beat_q} : a_q;

  a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> fetch_ready);
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  a_r6_bypass_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> $past(cfg_enable));
  a_r7_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FILL) && flk_q) |-> (!dat_we && !tag_we && !(mru_we && !ev_hit)));
endmodule

// File: tb/rc_cache_tb.sv
module rc_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_update_lock = 1'b0, cfg_read_lock = 1'b0;
  logic fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic fetch_ready, resp_valid, resp_hit, mem_req;
  logic [31:0] resp_data;
  logic [15:0] mem_addr;
  logic mem_rvalid;
  logic [31:0] mem_rdata;
  logic dbg_req = 1'b0;
  logic [2:0] dbg_set = '0;
  logic dbg_way = 1'b0;
  logic [2:0] dbg_word = '0;
  logic dbg_rvalid, dbg_denied, dbg_line_valid, dbg_mru;
  logic [9:0] dbg_tag;
  logic [3:0] dbg_unit_valid;
  logic [31:0] dbg_data;

  int errors = 0;
  int checks = 0;
  int reads = 0;
  int lat = 0;

  always #10 clk = ~clk;

  rc_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_update_lock(cfg_update_lock),
    .cfg_read_lock(cfg_read_lock), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_hit(resp_hit), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .dbg_req(dbg_req), .dbg_set(dbg_set), .dbg_way(dbg_way),
    .dbg_word(dbg_word), .dbg_rvalid(dbg_rvalid), .dbg_denied(dbg_denied), .dbg_tag(dbg_tag),
    .dbg_line_valid(dbg_line_valid), .dbg_unit_valid(dbg_unit_valid), .dbg_data(dbg_data),
    .dbg_mru(dbg_mru)
  );

  function automatic logic [31:0] mv(input logic [15:0] a);
    return {~a, a};
  endfunction

  // backing memory: two idle cycles, then one word per request
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_rvalid) begin
        if (lat == 2) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mv(mem_addr);
          reads++;
          lat = 0;
        end else lat++;
      end else begin
        mem_rvalid = 1'b0;
        lat = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one fetch; exp_reads < 0 skips the memory read count
  task automatic fetch(input logic [15:0] a, input bit exp_hit, input int exp_reads, input string rq);
    int r0;
    int waits;
    for (int i = 0; i < 100 && !fetch_ready; i++) @(negedge clk);
    r0 = reads;
    fetch_valid = 1'b1;
    fetch_addr  = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    waits = 0;
    for (int i = 0; i < 100 && !resp_valid; i++) begin
      @(negedge clk);
      waits++;
    end
    chk(resp_valid, rq, "response seen", 32'(resp_valid), 32'd1);
    chk(resp_hit == exp_hit, rq, "hit flag", 32'(resp_hit), 32'(exp_hit));
    chk(resp_data == mv(a), rq, "data", resp_data, mv(a));
    if (exp_hit) chk(waits == 1, "R2", "hit latency", 32'(waits), 32'd1);
    if (exp_reads >= 0) chk(reads - r0 == exp_reads, rq, "memory reads", 32'(reads - r0), 32'(exp_reads));
    @(negedge clk);
  endtask

  task automatic dbg_read(input logic [2:0] s, input logic w, input logic [2:0] wd);
    dbg_req = 1'b1; dbg_set = s; dbg_way = w; dbg_word = wd;
    @(negedge clk);
    dbg_req = 1'b0;
  endtask

  task automatic t_reset;
    chk(fetch_ready == 1'b1, "R10", "ready after reset", 32'(fetch_ready), 32'd1);
    chk(resp_valid == 1'b0, "R10", "no response after reset", 32'(resp_valid), 32'd0);
    chk(mem_req == 1'b0, "R10", "no memory request after reset", 32'(mem_req), 32'd0);
    dbg_read(3'd0, 1'b0, 3'd0);
    chk(dbg_line_valid == 1'b0, "R10", "line invalid after reset", 32'(dbg_line_valid), 32'd0);
  endtask

  task automatic t_basic;
    cfg_enable = 1'b1;
    fetch(16'h0040, 1'b0, 2, "R3");   // tag 1, set 0, unit 0 -> way 0
    fetch(16'h0040, 1'b1, 0, "R2");
    fetch(16'h0041, 1'b1, 0, "R1");   // same unit, other word
    fetch(16'h0042, 1'b0, 2, "R4");   // unit 1 on matching line
    fetch(16'h0040, 1'b1, 0, "R4");   // unit 0 kept
    dbg_read(3'd0, 1'b0, 3'd2);
    chk(dbg_rvalid, "R9", "debug valid", 32'(dbg_rvalid), 32'd1);
    chk(dbg_tag == 10'd1, "R9", "tag", 32'(dbg_tag), 32'd1);
    chk(dbg_unit_valid == 4'b0011, "R4", "unit flags kept", 32'(dbg_unit_valid), 32'h3);
    chk(dbg_data == mv(16'h0042), "R1", "word 2 in unit 1", dbg_data, mv(16'h0042));
    chk(dbg_mru == 1'b0, "R5", "mru way 0", 32'(dbg_mru), 32'd0);
  endtask

  task automatic t_disabled;
    cfg_enable = 1'b0;
    fetch(16'h0040, 1'b0, 1, "R6");
    fetch(16'h0080, 1'b0, 1, "R6");
    dbg_read(3'd0, 1'b1, 3'd0);
    chk(dbg_line_valid == 1'b0, "R6", "bypass left way 1 empty", 32'(dbg_line_valid), 32'd0);
    cfg_enable = 1'b1;
    fetch(16'h0040, 1'b1, 0, "R6");
  endtask

  task automatic t_replace;
    fetch(16'h0080, 1'b0, 2, "R5");   // free way 1
    dbg_read(3'd0, 1'b1, 3'd0);
    chk(dbg_tag == 10'd2, "R5", "tag 2 in way 1", 32'(dbg_tag), 32'd2);
    chk(dbg_unit_valid == 4'b0001, "R4", "new line single unit", 32'(dbg_unit_valid), 32'h1);
    chk(dbg_mru == 1'b1, "R5", "mru after fill", 32'(dbg_mru), 32'd1);
    fetch(16'h0040, 1'b1, 0, "R5");   // mru -> way 0
    fetch(16'h00C0, 1'b0, 2, "R5");   // evicts way 1 (tag 2)
    fetch(16'h0040, 1'b1, 0, "R5");
    fetch(16'h0080, 1'b0, 2, "R5");   // evicts way 1 (tag 3)
    fetch(16'h00C0, 1'b0, 2, "R5");   // evicts way 0 (tag 1)
    fetch(16'h0080, 1'b1, 0, "R5");
    fetch(16'h0040, 1'b0, 2, "R5");   // evicts way 0 (tag 3)
  endtask

  task automatic t_update_lock;
    fetch(16'h0050, 1'b0, 2, "R7");   // set 2, way 0
    cfg_update_lock = 1'b1;
    fetch(16'h0050, 1'b1, 0, "R7");
    fetch(16'h0150, 1'b0, 2, "R7");
    fetch(16'h0150, 1'b0, 2, "R7");
    dbg_read(3'd2, 1'b1, 3'd0);
    chk(dbg_line_valid == 1'b0, "R7", "no fill under lock", 32'(dbg_line_valid), 32'd0);
    chk(dbg_mru == 1'b0, "R7", "mru untouched under lock", 32'(dbg_mru), 32'd0);
    cfg_update_lock = 1'b0;
    fetch(16'h0050, 1'b1, 0, "R7");
    fetch(16'h0150, 1'b0, 2, "R7");
    fetch(16'h0150, 1'b1, 0, "R7");
  endtask

  // debug read captured at the same edge as the fill's tag write
  task automatic t_overlap;
    int r0;
    dbg_req = 1'b1; dbg_set = 3'd3; dbg_way = 1'b0; dbg_word = 3'd0;
    r0 = reads;
    fetch_valid = 1'b1;
    fetch_addr  = 16'h0058;
    @(negedge clk);
    fetch_valid = 1'b0;
    for (int i = 0; i < 100 && !resp_valid; i++) @(negedge clk);
    chk(resp_valid && !resp_hit && resp_data == mv(16'h0058), "R9", "fill under debug traffic",
        resp_data, mv(16'h0058));
    chk(dbg_line_valid == 1'b0, "R9", "same-edge read sees old line", 32'(dbg_line_valid), 32'd0);
    @(negedge clk);
    dbg_req = 1'b0;
    chk(dbg_line_valid == 1'b1, "R9", "next read sees new line", 32'(dbg_line_valid), 32'd1);
    chk(dbg_data == mv(16'h0058), "R9", "filled word", dbg_data, mv(16'h0058));
    chk(reads - r0 == 2, "R3", "unit-only fill", 32'(reads - r0), 32'd2);
  endtask

  task automatic t_read_lock;
    dbg_read(3'd0, 1'b0, 3'd0);
    chk(dbg_denied == 1'b0, "R8", "open before lock", 32'(dbg_denied), 32'd0);
    cfg_read_lock = 1'b1;
    @(negedge clk);
    cfg_read_lock = 1'b0;
    dbg_read(3'd0, 1'b0, 3'd0);
    chk(dbg_denied == 1'b1, "R8", "denied", 32'(dbg_denied), 32'd1);
    chk(dbg_tag == 10'd0 && dbg_data == 32'd0 && dbg_line_valid == 1'b0, "R8", "fields blanked",
        dbg_data, 32'd0);
    fetch(16'h0040, 1'b1, 0, "R8");
    dbg_read(3'd3, 1'b0, 3'd0);
    chk(dbg_denied == 1'b1, "R8", "lock persists", 32'(dbg_denied), 32'd1);
    do_reset();
    dbg_read(3'd0, 1'b0, 3'd0);
    chk(dbg_denied == 1'b0, "R8", "reset clears lock", 32'(dbg_denied), 32'd0);
    chk(dbg_line_valid == 1'b0, "R10", "reset clears lines", 32'(dbg_line_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_disabled();
    t_replace();
    t_update_lock();
    t_overlap();
    t_read_lock();
    report();
    $finish;
  end
endmodule